// File: doc/BRIEF.md
# Ethernet Destination Address Hash Filter

This block decides whether a received frame should be kept, judging only by its 48-bit destination address. The receive path presents the address one byte per cycle, in the order the bytes appear on the wire, using a valid strobe and an end-of-frame marker. While the bytes arrive, a bit-serial reflected CRC-32 runs over them. The top bits of the finished CRC index a 64-bit hash table. Individual addresses use one table and group addresses use a second table. In parallel, an individual address is compared exactly against a programmed station address.

Software loads the station address, the two hash tables and a small control word through a single-cycle register write port. One cycle after the sixth address byte is taken, the block gives a one-cycle verdict. The verdict has an accept flag and flags saying which rule matched. A promiscuous control bit accepts every address. The all-ones broadcast address is accepted unless a reject-broadcast control bit is set. Once the sixth byte has been taken, any remaining bytes of the frame are ignored until the end-of-frame marker.

Top module: `da_hash_filter`

## Requirements
- R1: The CRC starts at all ones for each address. Each byte is taken least significant bit first. For each bit, the register shifts right, and it is also XORed with 0xEDB88320 when the incoming bit differs from the register's old bit 0. Exactly six bytes are used, and no final inversion is applied.
- R2: The hash index is CRC bits [31:26]. An index of 32 to 63 selects bit (index-32) of the upper table word. An index of 0 to 31 selects that bit of the lower table word.
- R3: Write select values: 0 loads station bytes 0..3, with byte 0 in bits 31:24. Select 1 loads bytes 4 and 5 in bits 31:16; bits 15:0 are ignored and by convention carry 0x8808. Select 2 is control (bit 0 promiscuous, bit 1 reject broadcast). Selects 4 and 5 are the individual table's lower and upper words. Selects 8 and 9 are the group table's lower and upper words.
- R4: out_exact is set when an individual address equals the station address, and the address is then accepted.
- R5: out_ihash is set when an individual address selects a set bit in the individual table, and the address is then accepted.
- R6: An address whose first byte has bit 0 set is a group address. A group address consults only the group table (out_ghash), and the individual table and the station address have no effect on it.
- R7: The verdict is valid for exactly one cycle. That cycle is the one following the clock edge that takes the sixth byte.
- R8: An end-of-frame marker on or before the fifth byte discards the partial address and produces no verdict. Bytes after the sixth, up to and including the marker, are ignored.
- R9: The all-ones address raises out_bcast. It is accepted unless the reject-broadcast bit is set, in which case it is rejected whatever the group table holds.
- R10: With the promiscuous bit set, every address is accepted.
- R11: After reset, all outputs are 0 and all registers hold zero. Outside a verdict cycle all flags are 0. An address that matches no rule is rejected.
- R12: A register write takes effect for addresses whose sixth byte is taken in a later cycle. A write in the same cycle as the sixth byte does not affect that verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register select |
| cfg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Address byte valid |
| in_last | input | 1 | Last byte of the frame |
| in_byte | input | 8 | Address byte, wire order |
| out_valid | output | 1 | Verdict valid (one cycle) |
| out_accept | output | 1 | Frame accepted |
| out_exact | output | 1 | Station address match |
| out_ihash | output | 1 | Individual hash table hit |
| out_ghash | output | 1 | Group hash table hit |
| out_bcast | output | 1 | Address is broadcast |

## Verification
The bench builds the block with its default six-bit hash index, which gives two 32-bit words per table. It searches for addresses that land in each word, so both halves of the index split are exercised with single-bit and all-but-one-bit tables. A reference model in the bench recomputes the CRC and the verdict on every clock. This covers aborted and over-long byte streams, and a register write that coincides with the sixth byte.

// File: rtl/addr_filt_pkg.sv
package addr_filt_pkg;
   localparam int ADDR_BYTES = 6;
   localparam int ADDR_W     = 8 * ADDR_BYTES;
   localparam int REG_W      = 32;
   localparam int SEL_W      = 4;

   localparam logic [SEL_W-1:0] SEL_STA_HI   = 4'd0;
   localparam logic [SEL_W-1:0] SEL_STA_LO   = 4'd1;
   localparam logic [SEL_W-1:0] SEL_CTRL     = 4'd2;
   localparam int               SEL_IND_BASE = 4;
   localparam int               SEL_GRP_BASE = 8;

   typedef struct packed {
      logic promisc;
      logic bc_reject;
   } ctrl_t;

   typedef struct packed {
      logic exact;
      logic ihash;
      logic ghash;
      logic bcast;
      logic accept;
   } verdict_t;

   // one byte through a reflected CRC, low bit first
   function automatic logic [31:0] crc_feed_byte(input logic [31:0] c,
                                                 input logic [7:0]  b,
                                                 input logic [31:0] poly);
      logic [31:0] r;
      r = c;
      for (int i = 0; i < 8; i++) begin
         if (b[i] ^ r[0]) r = (r >> 1) ^ poly;
         else             r = r >> 1;
      end
      return r;
   endfunction
endpackage

// File: rtl/afilt_cfg_regs.sv
module afilt_cfg_regs
   import addr_filt_pkg::*;
#(
   parameter int HASH_BITS = 6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [SEL_W-1:0]          sel,
   input  logic [REG_W-1:0]          wdata,
   output logic [ADDR_W-1:0]         sta_addr,
   output ctrl_t                     ctrl,
   output logic [(1<<HASH_BITS)-1:0] itab,
   output logic [(1<<HASH_BITS)-1:0] gtab
);
   localparam int TAB_BITS   = 1 << HASH_BITS;
   localparam int HASH_WORDS = TAB_BITS / REG_W;

   logic [REG_W-1:0] sta_hi_q;
   logic [15:0]      sta_lo_q;
   ctrl_t            ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sta_hi_q <= '0;
         sta_lo_q <= '0;
         ctrl_q   <= '0;
      end else if (we) begin
         if (sel == SEL_STA_HI) sta_hi_q <= wdata;
         if (sel == SEL_STA_LO) sta_lo_q <= wdata[31:16];
         if (sel == SEL_CTRL) begin
            ctrl_q.promisc   <= wdata[0];
            ctrl_q.bc_reject <= wdata[1];
         end
      end
   end

   assign sta_addr = {sta_hi_q, sta_lo_q};
   assign ctrl     = ctrl_q;

   for (genvar w = 0; w < HASH_WORDS; w++) begin : g_word
      localparam logic [SEL_W-1:0] IND_SEL = SEL_W'(SEL_IND_BASE + w);
      localparam logic [SEL_W-1:0] GRP_SEL = SEL_W'(SEL_GRP_BASE + w);
      logic [REG_W-1:0] iw_q;
      logic [REG_W-1:0] gw_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            iw_q <= '0;
            gw_q <= '0;
         end else if (we) begin
            if (sel == IND_SEL) iw_q <= wdata;
            if (sel == GRP_SEL) gw_q <= wdata;
         end
      end
      assign itab[w*REG_W +: REG_W] = iw_q;
      assign gtab[w*REG_W +: REG_W] = gw_q;
   end
endmodule

// File: rtl/afilt_addr_shift.sv
module afilt_addr_shift
   import addr_filt_pkg::*;
#(
   parameter int          HASH_BITS = 6,
   parameter logic [31:0] POLY      = 32'hEDB88320,
   parameter logic [31:0] CRC_INIT  = 32'hFFFFFFFF
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic                 in_last,
   input  logic [7:0]           in_byte,
   output logic                 done,
   output logic [ADDR_W-1:0]    full_addr,
   output logic [HASH_BITS-1:0] hash_idx
);
   localparam int CNT_W = $clog2(ADDR_BYTES);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);

   logic [CNT_W-1:0]    cnt_q;
   logic [31:0]         crc_q;
   logic [31:0]         crc_nxt;
   logic [ADDR_W-9:0]   addr_q;
   logic                skip_q;
   logic                take;

   assign take      = in_valid && !skip_q;
   assign done      = take && (cnt_q == LAST_IDX);
   assign crc_nxt   = crc_feed_byte(crc_q, in_byte, POLY);
   assign full_addr = {addr_q, in_byte};
   assign hash_idx  = crc_nxt[31 -: HASH_BITS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         crc_q  <= CRC_INIT;
         addr_q <= '0;
         skip_q <= 1'b0;
      end else if (in_valid) begin
         if (skip_q) begin
            if (in_last) skip_q <= 1'b0;
         end else begin
            addr_q <= {addr_q[ADDR_W-17:0], in_byte};
            if (done || in_last) begin
               cnt_q  <= '0;
               crc_q  <= CRC_INIT;
               skip_q <= done && !in_last;
            end else begin
               cnt_q  <= cnt_q + 1'b1;
               crc_q  <= crc_nxt;
            end
         end
      end
   end

   assert_cnt_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST_IDX);
   assert_skip_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      skip_q |-> (cnt_q == '0 && crc_q == CRC_INIT));
endmodule

// File: rtl/afilt_match.sv
module afilt_match
   import addr_filt_pkg::*;
#(
   parameter int HASH_BITS = 6
) (
   input  logic [ADDR_W-1:0]         full_addr,
   input  logic [HASH_BITS-1:0]      hash_idx,
   input  logic [ADDR_W-1:0]         sta_addr,
   input  ctrl_t                     ctrl,
   input  logic [(1<<HASH_BITS)-1:0] itab,
   input  logic [(1<<HASH_BITS)-1:0] gtab,
   output verdict_t                  verdict
);
   logic is_grp;
   logic is_bc;

   assign is_grp = full_addr[ADDR_W-8];
   assign is_bc  = &full_addr;

   always_comb begin
      verdict.bcast  = is_bc;
      verdict.exact  = !is_grp && (full_addr == sta_addr);
      verdict.ihash  = !is_grp && itab[hash_idx];
      verdict.ghash  = is_grp && gtab[hash_idx];
      verdict.accept = ctrl.promisc || verdict.exact || verdict.ihash ||
                       (is_bc ? !ctrl.bc_reject : verdict.ghash);
   end
endmodule

// File: rtl/da_hash_filter.sv
module da_hash_filter
   import addr_filt_pkg::*;
#(
   parameter int          HASH_BITS = 6,
   parameter logic [31:0] POLY      = 32'hEDB88320,
   parameter logic [31:0] CRC_INIT  = 32'hFFFFFFFF
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic [3:0]  cfg_sel,
   input  logic [31:0] cfg_wdata,
   input  logic        in_valid,
   input  logic        in_last,
   input  logic [7:0]  in_byte,
   output logic        out_valid,
   output logic        out_accept,
   output logic        out_exact,
   output logic        out_ihash,
   output logic        out_ghash,
   output logic        out_bcast
);
   localparam int TAB_BITS = 1 << HASH_BITS;

   if (HASH_BITS < 5 || HASH_BITS > 7) begin : g_bad_hash
      $error("HASH_BITS must be 5..7 so tables fit the select map");
   end

   logic [ADDR_W-1:0]    sta_addr;
   ctrl_t                ctrl;
   logic [TAB_BITS-1:0]  itab;
   logic [TAB_BITS-1:0]  gtab;
   logic                 done;
   logic [ADDR_W-1:0]    full_addr;
   logic [HASH_BITS-1:0] hash_idx;
   verdict_t             verdict;
   verdict_t             res_q;
   logic                 valid_q;

   afilt_cfg_regs #(.HASH_BITS(HASH_BITS)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
      .sta_addr(sta_addr), .ctrl(ctrl), .itab(itab), .gtab(gtab));

   afilt_addr_shift #(.HASH_BITS(HASH_BITS), .POLY(POLY), .CRC_INIT(CRC_INIT)) u_shift (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
      .in_byte(in_byte), .done(done), .full_addr(full_addr), .hash_idx(hash_idx));

   afilt_match #(.HASH_BITS(HASH_BITS)) u_match (
      .full_addr(full_addr), .hash_idx(hash_idx), .sta_addr(sta_addr),
      .ctrl(ctrl), .itab(itab), .gtab(gtab), .verdict(verdict));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         res_q   <= '0;
      end else begin
         valid_q <= done;
         res_q   <= done ? verdict : '0;
      end
   end

   assign out_valid  = valid_q;
   assign out_accept = res_q.accept;
   assign out_exact  = res_q.exact;
   assign out_ihash  = res_q.ihash;
   assign out_ghash  = res_q.ghash;
   assign out_bcast  = res_q.bcast;

   assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);
   assert_result_timing_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> out_valid);
   assert_quiet_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> !(out_accept || out_exact || out_ihash || out_ghash || out_bcast));
   assert_promisc_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(ctrl.promisc)) |-> out_accept);
   assert_bcast_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_bcast && $past(ctrl.bc_reject) && !$past(ctrl.promisc))
      |-> !out_accept);
   assert_group_tables_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_ghash |-> !(out_exact || out_ihash));
endmodule

// File: tb/da_hash_filter_bench.sv
module da_hash_filter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic        in_valid = 1'b0;
   logic        in_last = 1'b0;
   logic [7:0]  in_byte = '0;
   logic        out_valid, out_accept, out_exact, out_ihash, out_ghash, out_bcast;

   int checks = 0;
   int errors = 0;
   int pulses = 0;
   string cur_req = "R11";

   always #5 clk = ~clk;

   da_hash_filter u_da_hash_filter (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_last(in_last),
      .in_byte(in_byte), .out_valid(out_valid), .out_accept(out_accept),
      .out_exact(out_exact), .out_ihash(out_ihash), .out_ghash(out_ghash),
      .out_bcast(out_bcast));

   // ---------------- reference model ----------------
   logic [31:0] m_sta_hi = '0;
   logic [15:0] m_sta_lo = '0;
   logic [63:0] m_itab = '0;
   logic [63:0] m_gtab = '0;
   logic        m_prom = 1'b0;
   logic        m_bcrej = 1'b0;
   logic [7:0]  m_q[$];
   bit          m_skip = 1'b0;
   logic [5:0]  e_v = '0; // {valid, accept, exact, ihash, ghash, bcast}

   function automatic int ref_idx(input logic [47:0] a);
      bit [31:0] c = 32'hFFFFFFFF;
      for (int i = 0; i < 6; i++) begin
         logic [7:0] b = a[47-8*i -: 8];
         for (int k = 0; k < 8; k++) begin
            bit fb = b[k] ^ c[0];
            c = c >> 1;
            if (fb) c = c ^ 32'hEDB88320;
         end
      end
      return int'(c[31:26]);
   endfunction

   function automatic logic [5:0] ref_verdict(input logic [47:0] a);
      bit grp = a[40];
      bit bc  = (a == 48'hFFFFFFFFFFFF);
      int idx = ref_idx(a);
      bit ex  = !grp && (a == {m_sta_hi, m_sta_lo});
      bit ih  = !grp && m_itab[idx];
      bit gh  = grp && m_gtab[idx];
      bit acc = m_prom || ex || ih || (bc ? !m_bcrej : gh);
      return {1'b1, acc, ex, ih, gh, bc};
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_sta_hi = '0; m_sta_lo = '0; m_itab = '0; m_gtab = '0;
         m_prom = 0; m_bcrej = 0; m_q.delete(); m_skip = 0; e_v = '0;
      end else begin
         e_v = '0;
         if (in_valid) begin
            if (m_skip) begin
               if (in_last) m_skip = 0;
            end else begin
               m_q.push_back(in_byte);
               if (m_q.size() == 6) begin
                  e_v = ref_verdict({m_q[0], m_q[1], m_q[2], m_q[3], m_q[4], m_q[5]});
                  m_q.delete();
                  m_skip = !in_last;
               end else if (in_last) begin
                  m_q.delete();
               end
            end
         end
         if (cfg_we) begin
            case (cfg_sel)
               4'd0: m_sta_hi = cfg_wdata;
               4'd1: m_sta_lo = cfg_wdata[31:16];
               4'd2: begin m_prom = cfg_wdata[0]; m_bcrej = cfg_wdata[1]; end
               4'd4: m_itab[31:0]  = cfg_wdata;
               4'd5: m_itab[63:32] = cfg_wdata;
               4'd8: m_gtab[31:0]  = cfg_wdata;
               4'd9: m_gtab[63:32] = cfg_wdata;
               default: ;
            endcase
         end
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      logic [5:0] act;
      act = {out_valid, out_accept, out_exact, out_ihash, out_ghash, out_bcast};
      checks++;
      if (out_valid === 1'b1) pulses++;
      if (act !== e_v) begin
         errors++;
         $display("FAIL %s model compare actual=%b expected=%b (valid,acc,exact,ih,gh,bc)",
                  (act[5] !== e_v[5]) ? "R7" : cur_req, act, e_v);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic cfg_write(input logic [3:0] s, input logic [31:0] d);
      @(negedge clk); cfg_we = 1; cfg_sel = s; cfg_wdata = d;
      @(negedge clk); cfg_we = 0;
   endtask

   task automatic set_tables(input logic [63:0] it, input logic [63:0] gt);
      cfg_write(4'd4, it[31:0]); cfg_write(4'd5, it[63:32]);
      cfg_write(4'd8, gt[31:0]); cfg_write(4'd9, gt[63:32]);
   endtask

   task automatic send_addr(input logic [47:0] a, input bit with_last,
                            input bit wr, input logic [3:0] ws, input logic [31:0] wd);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         in_valid = 1; in_byte = a[47-8*i -: 8]; in_last = with_last && (i == 5);
         if (i == 5 && wr) begin cfg_we = 1; cfg_sel = ws; cfg_wdata = wd; end
      end
   endtask

   task automatic check(input bit cond, input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (!cond) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // result is visible at the negedge after the sixth byte's edge
   task automatic expect_res(input string req, input bit acc, input logic [3:0] flags);
      logic [3:0] f;
      @(negedge clk); in_valid = 0; in_last = 0; cfg_we = 0;
      f = {out_exact, out_ihash, out_ghash, out_bcast};
      check(out_valid === 1'b1, req, "verdict valid", {7'd0, out_valid}, 8'd1);
      check(out_accept === acc, req, "accept", {7'd0, out_accept}, {7'd0, acc});
      check(f === flags, req, "flags ex/ih/gh/bc", {4'd0, f}, {4'd0, flags});
   endtask

   localparam logic [47:0] STA = 48'h021122334455;

   initial begin
      repeat (3) @(negedge clk);
      cur_req = "R11";
      check({out_valid, out_accept, out_exact, out_ihash, out_ghash, out_bcast} === 6'd0,
            "R11", "outputs in reset", {2'd0, out_valid, out_accept, out_exact,
            out_ihash, out_ghash, out_bcast}, 8'd0);
      rst_n = 1;
      // reset station is zero: the zero address must match exactly
      send_addr(48'h0, 1, 0, 0, 0);
      expect_res("R11", 1, 4'b1000);

      cur_req = "R3";
      cfg_write(4'd0, STA[47:16]);
      cfg_write(4'd1, {STA[15:0], 16'h8808});
      send_addr(STA, 1, 0, 0, 0);
      expect_res("R3", 1, 4'b1000);
      cfg_write(4'd1, {STA[15:0], 16'h1234});
      cur_req = "R4";
      send_addr(STA, 1, 0, 0, 0);
      expect_res("R4", 1, 4'b1000);
      @(negedge clk);
      check(out_valid === 1'b0, "R7", "valid lasts one cycle", {7'd0, out_valid}, 8'd0);

      cur_req = "R11";
      send_addr(STA ^ 48'h1, 1, 0, 0, 0);
      expect_res("R11", 0, 4'b0000);

      cur_req = "R12";
      send_addr(STA, 1, 1, 4'd0, 32'hDEADBEE0);
      expect_res("R12", 1, 4'b1000);
      send_addr(STA, 1, 0, 0, 0);
      expect_res("R12", 0, 4'b0000);
      cfg_write(4'd0, STA[47:16]);

      // index split across words
      cur_req = "R2";
      begin
         logic [47:0] a_hi = '0, a_lo = '0;
         bit f_hi = 0, f_lo = 0;
         for (int k = 0; k < 256; k++) begin
            logic [47:0] a = 48'h0A0000000000 | 48'(k);
            int ix = ref_idx(a);
            if (ix >= 32 && !f_hi) begin a_hi = a; f_hi = 1; end
            if (ix < 32 && !f_lo) begin a_lo = a; f_lo = 1; end
         end
         set_tables(64'd1 << ref_idx(a_hi), 64'd0);
         send_addr(a_hi, 1, 0, 0, 0);
         expect_res("R2", 1, 4'b0100);
         send_addr(a_lo, 1, 0, 0, 0);
         expect_res("R2", 0, 4'b0000);
         set_tables(64'd1 << ref_idx(a_lo), 64'd0);
         send_addr(a_lo, 1, 0, 0, 0);
         expect_res("R2", 1, 4'b0100);
      end

      // CRC pinned down by single-bit and all-but-one tables
      for (int j = 0; j < 12; j++) begin
         logic [47:0] a = 48'h0A1B2C3D4E00 + 48'(j * 37);
         logic [63:0] t = 64'd1 << ref_idx(a);
         cur_req = "R1";
         set_tables(t, 64'd0);
         send_addr(a, 1, 0, 0, 0);
         expect_res("R1", 1, 4'b0100);
         cur_req = "R5";
         set_tables(~t, 64'd0);
         send_addr(a, 1, 0, 0, 0);
         expect_res("R5", 0, 4'b0000);
      end

      cur_req = "R6";
      begin
         logic [47:0] g = 48'h01005E000001;
         logic [63:0] t = 64'd1 << ref_idx(g);
         set_tables(64'd0, t);
         send_addr(g, 1, 0, 0, 0);
         expect_res("R6", 1, 4'b0010);
         set_tables(t, 64'd0);
         send_addr(g, 1, 0, 0, 0);
         expect_res("R6", 0, 4'b0000);
         set_tables(64'd0, 64'd0);
      end

      cur_req = "R9";
      send_addr(48'hFFFFFFFFFFFF, 1, 0, 0, 0);
      expect_res("R9", 1, 4'b0001);
      cfg_write(4'd2, 32'h2);
      set_tables(64'd0, '1);
      send_addr(48'hFFFFFFFFFFFF, 1, 0, 0, 0);
      expect_res("R9", 0, 4'b0011);
      set_tables(64'd0, 64'd0);

      cur_req = "R10";
      cfg_write(4'd2, 32'h3);
      send_addr(48'hFFFFFFFFFFFF, 1, 0, 0, 0);
      expect_res("R10", 1, 4'b0001);
      send_addr(48'h0A0B0C0D0E0F, 1, 0, 0, 0);
      expect_res("R10", 1, 4'b0000);
      cfg_write(4'd2, 32'h0);

      cur_req = "R8";
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); in_valid = 1; in_byte = 8'hA0 + 8'(i); in_last = (i == 2);
      end
      @(negedge clk); in_valid = 0; in_last = 0;
      repeat (3) @(negedge clk);
      check(out_valid === 1'b0, "R8", "no verdict after abort", {7'd0, out_valid}, 8'd0);
      send_addr(STA, 0, 0, 0, 0);
      pulses = 0;
      for (int i = 0; i < 9; i++) begin
         @(negedge clk); in_valid = 1; in_byte = STA[47-8*(i%6) -: 8]; in_last = (i == 8);
      end
      @(negedge clk); in_valid = 0; in_last = 0;
      repeat (3) @(negedge clk);
      check(pulses == 1, "R8", "verdicts for one over-long frame", 8'(pulses), 8'd1);
      send_addr(STA, 1, 0, 0, 0);
      expect_res("R8", 1, 4'b1000);

      repeat (4) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R7 watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule